// File: doc/BRIEF.md
# Flash write-status read multiplexer

This block sits on the read path of a flash controller and decides what a read returns. With no internal operation running and no erase suspended, reads return the array word unchanged. While a program or erase runs inside the device, the array is not readable, so the block returns a status word instead. Software polls that word to find out when the operation has finished.

The status word carries a completion-polling bit and a busy toggle bit. The toggle bit flips on every read strobe for as long as the operation runs. When an erase is suspended, reads that land in the suspended sector or block return a separate pattern: a region toggle bit flips on each such read and a fixed marker bit is held at 1. Reads elsewhere return array data as normal. The command controller supplies the busy flag, the operation type, bit 7 of the word being programmed, the suspend flag and the suspended address with its granularity. The block owns only the two toggle registers.

Top module: `flash_status_mux`

## Requirements
- R1: After reset both toggle registers hold 0, so the first status read returns bit 6 = 0 and the first suspended-region read returns bit 2 = 0.
- R2: With busy_i low and susp_i low, rd_data_o equals arr_data_i.
- R3: With busy_i high and op_erase_i low (program), bit 7 of rd_data_o is the inverse of prog_msb_i.
- R4: With busy_i high and op_erase_i high (erase), bit 7 of rd_data_o is 0.
- R5: With busy_i high, bit 6 of rd_data_o shows the busy toggle register, which inverts at each clock edge where rd_stb_i is high. All bits other than 7 and 6 are 0.
- R6: With busy_i low, the busy toggle register keeps its value whatever rd_stb_i does, so the next busy read continues from the held value.
- R7: With busy_i low, susp_i high and rd_addr_i inside the suspended region, rd_data_o has bit 7 = 1, bit 6 = 1, bit 2 = region toggle register, and all other bits 0.
- R8: The region toggle register inverts only at clock edges where rd_stb_i is high, busy_i is low, and the address is inside the suspended region. Busy reads and out-of-region reads leave it unchanged.
- R9: With busy_i low, susp_i high and rd_addr_i outside the suspended region, rd_data_o equals arr_data_i.
- R10: The region is given by susp_addr_i. With susp_blk_i low, the address bits from SEC_LSB (11) upward are compared. With susp_blk_i high, the bits from BLK_LSB (15) upward are compared.
- R11: busy_i takes precedence over susp_i. A program run during a suspend returns the R3/R5 status even inside the suspended region.
- R12: The output path is combinational. Status replaces array data in the same cycle that busy_i rises, and array data returns in the cycle busy_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program or erase is running |
| op_erase_i | input | 1 | 1 = running operation is an erase, 0 = program |
| prog_msb_i | input | 1 | Bit 7 of the word being programmed |
| susp_i | input | 1 | An erase is suspended |
| susp_blk_i | input | 1 | 1 = suspended region is a block, 0 = a sector |
| susp_addr_i | input | AW | Any address inside the suspended region |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | AW | Read word address |
| arr_data_i | input | DW | Word read from the array |
| rd_data_o | output | DW | Data returned to the host |

## Verification
A busy toggle register stuck or flipping at the wrong moment shows as two identical bit-6 values on consecutive busy reads. It can also show as a bit-6 value, after an idle stretch, that differs from the one the bench carried over. Either way it appears on the very next status read. A wrong region toggle or a wrong region comparison shows on the next read inside the suspended region, either as a bit-2 value that failed to alternate or as array data where the status pattern belongs. Errors in the polling bit and in the precedence between busy and suspend show in the same cycle as the read, because the output has no register stage.

// File: rtl/flash_status_mux.sv
module flash_status_mux #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic          prog_msb_i,
  input  logic          susp_i,
  input  logic          susp_blk_i,
  input  logic [AW-1:0] susp_addr_i,
  input  logic          rd_stb_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int POLL_B = 7;
  localparam int TGL_B  = 6;
  localparam int REG_B  = 2;
  localparam logic [AW-1:0] SEC_MASK = {AW{1'b1}} << SEC_LSB;
  localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << BLK_LSB;

  logic          tgl_busy_q, tgl_reg_q;
  logic [AW-1:0] reg_mask;
  logic          in_region;

  assign reg_mask  = susp_blk_i ? BLK_MASK : SEC_MASK;
  assign in_region = susp_i && (((rd_addr_i ^ susp_addr_i) & reg_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_busy_q <= 1'b0;
      tgl_reg_q  <= 1'b0;
    end else if (rd_stb_i) begin
      if (busy_i)         tgl_busy_q <= ~tgl_busy_q;
      else if (in_region) tgl_reg_q  <= ~tgl_reg_q;
    end
  end

  always_comb begin
    rd_data_o = arr_data_i;
    if (busy_i) begin
      rd_data_o         = '0;
      rd_data_o[POLL_B] = ~op_erase_i & ~prog_msb_i;
      rd_data_o[TGL_B]  = tgl_busy_q;
    end else if (in_region) begin
      rd_data_o         = '0;
      rd_data_o[POLL_B] = 1'b1;
      rd_data_o[TGL_B]  = 1'b1;
      rd_data_o[REG_B]  = tgl_reg_q;
    end
  end
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          op_erase_i,
  input logic          prog_msb_i,
  input logic          susp_i,
  input logic          susp_blk_i,
  input logic [AW-1:0] susp_addr_i,
  input logic          rd_stb_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] rd_data_o
);
  logic in_r, sreg;
  assign in_r = susp_i && (susp_blk_i ? ((rd_addr_i >> BLK_LSB) == (susp_addr_i >> BLK_LSB))
                                      : ((rd_addr_i >> SEC_LSB) == (susp_addr_i >> SEC_LSB)));
  assign sreg = !busy_i && in_r;

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !susp_i) |-> rd_data_o == arr_data_i); // R2
  AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !op_erase_i) |-> rd_data_o[7] == !prog_msb_i); // R3
  AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && op_erase_i) |-> !rd_data_o[7]); // R4
  AST_BUSY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_stb_i) |=> (!busy_i || rd_data_o[6] != $past(rd_data_o[6]))); // R5
  AST_SUSP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    sreg |-> (rd_data_o[7] && rd_data_o[6])); // R7
  AST_REG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg && rd_stb_i) |=> (!sreg || rd_data_o[2] != $past(rd_data_o[2]))); // R8
  AST_SUSP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && susp_i && !in_r) |-> rd_data_o == arr_data_i); // R9
endmodule

bind flash_status_mux flash_status_chk #(.AW(AW), .DW(DW), .SEC_LSB(SEC_LSB), .BLK_LSB(BLK_LSB)) u_chk (.*);

// File: tb/sim_flash_status_mux.sv
module sim_flash_status_mux;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busy_i = 0, op_erase_i = 0, prog_msb_i = 0, susp_i = 0, susp_blk_i = 0, rd_stb_i = 0;
  logic [15:0] susp_addr_i = '0, rd_addr_i = '0, arr_data_i = '0;
  logic [15:0] rd_data_o;
  int checks = 0, failures = 0;
  logic m6 = 0, m2 = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_status_mux u0 (.*);

  function automatic logic inreg(logic s, logic blk, logic [15:0] sa, logic [15:0] a);
    logic [15:0] msk;
    msk = blk ? 16'h8000 : 16'hF800;
    return s && (((a ^ sa) & msk) == 16'h0);
  endfunction

  function automatic logic [15:0] expw();
    logic [15:0] w;
    if (busy_i) begin
      w = '0; w[7] = op_erase_i ? 1'b0 : ~prog_msb_i; w[6] = m6;
    end else if (inreg(susp_i, susp_blk_i, susp_addr_i, rd_addr_i)) begin
      w = '0; w[7] = 1'b1; w[6] = 1'b1; w[2] = m2;
    end else w = arr_data_i;
    return w;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic b, input logic e, input logic m, input logic s, input logic blk,
                    input logic [15:0] sa, input logic [15:0] a, input logic [15:0] d,
                    input logic stb, input string tag);
    @(negedge clk);
    busy_i = b; op_erase_i = e; prog_msb_i = m; susp_i = s; susp_blk_i = blk;
    susp_addr_i = sa; rd_addr_i = a; arr_data_i = d; rd_stb_i = stb;
    #2 chk(rd_data_o, expw(), tag);
    @(posedge clk);
    if (stb) begin
      if (b) m6 = ~m6;
      else if (inreg(s, blk, sa, a)) m2 = ~m2;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd(0,0,0,0,0,16'h0,16'h1234,16'hA5C3,1,"R2");
    @(negedge clk); busy_i = 1; op_erase_i = 0; prog_msb_i = 0; rd_stb_i = 0;
    #2 chk({15'h0, rd_data_o[6]}, 16'h0, "R1");
    chk(rd_data_o, 16'h0080, "R12");
    @(negedge clk); busy_i = 0; susp_i = 1; susp_addr_i = 16'h2800; rd_addr_i = 16'h2812;
    #2 chk(rd_data_o, 16'h00C0, "R1");
    rd(1,0,1,0,0,16'h0,16'h0,16'hFFFF,1,"R3");
    rd(1,0,0,0,0,16'h0,16'h0,16'hFFFF,1,"R3");
    rd(1,1,1,0,0,16'h0,16'h0,16'hFFFF,1,"R4");
    rd(1,1,0,0,0,16'h0,16'h0,16'hFFFF,1,"R5");
    rd(1,1,0,0,0,16'h0,16'h0,16'hFFFF,0,"R5");
    rd(0,0,0,0,0,16'h0,16'h0042,16'h3C3C,1,"R12");
    rd(0,0,0,0,0,16'h0,16'h0043,16'h0F0F,1,"R6");
    rd(0,0,0,0,0,16'h0,16'h0044,16'hF0F0,1,"R6");
    rd(1,0,0,0,0,16'h0,16'h0,16'h1111,1,"R6");
    rd(0,0,0,1,0,16'h2800,16'h2FFF,16'h1111,1,"R7");
    rd(0,0,0,1,0,16'h2800,16'h2801,16'h1111,1,"R7");
    rd(0,0,0,1,0,16'h2800,16'h3000,16'h7777,1,"R9");
    rd(1,0,1,1,0,16'h2800,16'h2800,16'h7777,1,"R11");
    rd(0,0,0,1,0,16'h2800,16'h2802,16'h1111,1,"R8");
    rd(0,0,0,1,0,16'h2800,16'h2802,16'h1111,0,"R8");
    rd(0,0,0,1,0,16'h2800,16'h2802,16'h1111,1,"R8");
    rd(0,0,0,1,1,16'h8000,16'hF123,16'h5555,1,"R10");
    rd(0,0,0,1,0,16'h8000,16'hF123,16'h5555,1,"R10");
    rd(0,0,0,1,1,16'h8000,16'h7123,16'h5555,1,"R10");
    rd(0,0,0,1,0,16'h8000,16'h8123,16'h5555,1,"R10");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] sa, a;
      logic b, s;
      string tag;
      sa = 16'($urandom);
      a  = $urandom_range(0, 1) ? (sa ^ 16'($urandom_range(0, 2047))) : 16'($urandom);
      b  = ($urandom_range(0, 2) == 0);
      s  = $urandom_range(0, 1);
      if (b) tag = "R5";
      else if (inreg(s, 1'b0, sa, a)) tag = "R7";
      else if (s) tag = "R9";
      else tag = "R2";
      rd(b, 1'($urandom), 1'($urandom), s, 1'b0, sa, a, 16'($urandom), 1'($urandom), tag);
    end
    finish_run();
  end
endmodule